// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard control unit of an in-order pipeline with five stages: fetch, decode, execute, memory and write-back. Each cycle the surrounding datapath gives it a summary of every stage.

- **Decode:** the instruction's source registers, which of them it reads, and whether it is an unconditional branch.
- **Execute:** the source registers, the destination register, the write enable, whether the instruction is a load, and whether it is a conditional branch and whether that branch was taken.
- **Memory:** the destination register, the write enable, and whether the instruction touches the data memory.
- **Write-back:** the destination register and the write enable.

From this snapshot the block works out, in the same cycle, four sets of controls:

- the operand bypass choice for the two execute-stage operands;
- hold enables for the program counter and for the fetch/decode register;
- bubble controls for the decode and execute entries;
- a next-PC source select.

Branches are predicted not taken. An unconditional branch is resolved in decode, which costs one wrong-path slot. A conditional branch is resolved in execute, which costs two slots.

The pipeline has a single memory port that serves both instruction fetch and data access. A memory-stage access therefore takes the port away from fetch for that cycle.

The block holds no state. Every output is a function of the current stage summaries. Outputs are forced to their inactive values while the active-low reset is asserted. After reset, the valid flags keep every control quiet until real instructions are in flight.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While rst_n is low, fwd_a, fwd_b and pc_sel are 00 and pc_hold, ifid_hold, ifid_bubble and idex_bubble are 0, whatever the other inputs are.
- R2: Each execute operand gets a 2-bit bypass select: 00 means the register file, 01 the write-back stage and 10 the memory stage. The memory stage is chosen when it is valid, writes, and its destination equals the operand's source register. This holds even when the write-back stage matches as well.
- R3: The select is never nonzero for source register 0. A stage that is invalid or has its write enable low never supplies a bypass.
- R4: A load-use hazard sets pc_hold, ifid_hold and idex_bubble to 1 and ifid_bubble to 0. It exists when execute holds a valid, writing load with a nonzero destination, and a valid decode instruction reads that register.
- R5: A decode source register that matches the load's destination raises no load-use stall when its use flag is clear.
- R6: A valid taken conditional branch in execute sets pc_sel to 10 and ifid_bubble and idex_bubble to 1. pc_hold and ifid_hold are 0 in that case.
- R7: A valid unconditional branch in decode, with no higher-priority event, sets pc_sel to 01 and ifid_bubble to 1. pc_hold, ifid_hold and idex_bubble are 0.
- R8: A valid memory-stage instruction that accesses memory, with no higher-priority event, sets pc_hold and ifid_bubble to 1. ifid_hold and idex_bubble are 0 and pc_sel is 00.
- R9: The event priority, from highest, is: taken conditional branch in execute, load-use stall, unconditional branch in decode, structural conflict. Only the highest-priority event present drives the stall, bubble and pc_sel outputs.
- R10: With no event present, pc_sel is 00 and all hold and bubble outputs are 0. A not-taken conditional branch counts as no event.
- R11: ifid_hold and ifid_bubble are never 1 together, and ifid_hold is never 1 without pc_hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used for the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | AW | Decode first source register |
| id_rs2 | input | AW | Decode second source register |
| id_use1 | input | 1 | Decode reads id_rs1 |
| id_use2 | input | 1 | Decode reads id_rs2 |
| id_uncond | input | 1 | Decode instruction is an unconditional branch |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_rs1 | input | AW | Execute first source register |
| ex_rs2 | input | AW | Execute second source register |
| ex_rd | input | AW | Execute destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_cond | input | 1 | Execute instruction is a conditional branch |
| ex_taken | input | 1 | Conditional branch outcome is taken |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_rd | input | AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_acc | input | 1 | Memory-stage instruction loads or stores |
| wb_valid | input | 1 | Write-back stage holds a real instruction |
| wb_rd | input | AW | Write-back destination register |
| wb_wen | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Bypass select for execute operand 1 |
| fwd_b | output | 2 | Bypass select for execute operand 2 |
| pc_sel | output | 2 | Next PC: 00 sequential, 01 decode target, 10 execute target |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_bubble | output | 1 | Load a bubble into the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
The bench targets the cases where two hazard sources meet.

- **Both later stages match an operand.** Memory and write-back both target the same register. A unit with the wrong bypass order hands execute the stale write-back value.
- **Register zero and non-writing stages.** A bench case writes register zero, and another uses a stage with its write enable low. A unit that forwards from either corrupts operands that must read as zero or as the file contents.
- **Load-use detection.** A load destination matches a decode source whose use flag is clear. Over-eager detection wastes a cycle there. The bench also covers load-use stalls combined with a taken branch, a jump, or a memory access. A wrong order either freezes wrong-path instructions behind a resolved branch, or overwrites a held decode entry with a bubble and loses an instruction.

// File: rtl/hzd_pkg.sv
// Shared encodings of the pipeline hazard controller.
// Assumes: bypass and next-PC selects are both two bits wide.
package hzd_pkg;

    // Operand bypass source for an execute-stage operand
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    // Next program counter source
    typedef enum logic [1:0] {
        PC_SEQ = 2'b00,
        PC_DEC = 2'b01,
        PC_EXE = 2'b10
    } pc_sel_e;

endpackage

// File: rtl/hzd_fwd_mux.sv
// Bypass select for one execute-stage source operand.
// Picks the youngest valid writer of the operand's register: memory stage
// first, then write-back, else the register file. Register 0 never bypasses.
// Assumes: the memory-stage result is already present in its pipeline register.
module hzd_fwd_mux
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic          mem_valid,
    input  logic          mem_wen,
    input  logic [AW-1:0] mem_rd,
    input  logic          wb_valid,
    input  logic          wb_wen,
    input  logic [AW-1:0] wb_rd,
    output logic [1:0]    sel
);
    logic src_nz;
    logic mem_hit;
    logic wb_hit;

    // Match the operand against each later stage's destination
    always_comb begin
        src_nz  = (src != '0);
        mem_hit = src_nz && mem_valid && mem_wen && (mem_rd == src);
        wb_hit  = src_nz && wb_valid && wb_wen && (wb_rd == src);
    end

    // Choose the bypass source, memory stage ahead of write-back
    always_comb begin
        if (!rst_n)       sel = FWD_RF;
        else if (mem_hit) sel = FWD_MEM;
        else if (wb_hit)  sel = FWD_WB;
        else              sel = FWD_RF;
    end

    // R3
    zero_reg_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == FWD_RF));
    // R2
    sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'b11);
endmodule

// File: rtl/hzd_detect.sv
// Raw hazard event detection from the stage summaries.
// Produces four independent flags; it applies no priority between them.
// Assumes: a load's data is available only at the end of the memory stage.
module hzd_detect #(
    parameter int AW = 5
) (
    input  logic          id_valid,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use1,
    input  logic          id_use2,
    input  logic          id_uncond,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic          ex_cond,
    input  logic          ex_taken,
    input  logic          mem_valid,
    input  logic          mem_acc,
    output logic          ev_ex_redirect,
    output logic          ev_load_use,
    output logic          ev_id_redirect,
    output logic          ev_struct
);
    logic load_live;
    logic src1_dep;
    logic src2_dep;

    // Load-use: a live load in execute feeds a register decode reads
    always_comb begin
        load_live   = ex_valid && ex_load && ex_wen && (ex_rd != '0);
        src1_dep    = id_use1 && (id_rs1 == ex_rd);
        src2_dep    = id_use2 && (id_rs2 == ex_rd);
        ev_load_use = load_live && id_valid && (src1_dep || src2_dep);
    end

    // Branch resolution and shared-port collision
    always_comb begin
        ev_ex_redirect = ex_valid && ex_cond && ex_taken;
        ev_id_redirect = id_valid && id_uncond;
        ev_struct      = mem_valid && mem_acc;
    end
endmodule

// File: rtl/hzd_arbiter.sv
// Orders the hazard events and drives the pipeline flow controls.
// Priority: execute redirect, load-use stall, decode redirect, structural.
// Assumes: the event flags are valid for the current cycle only.
module hzd_arbiter
    import hzd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_ex_redirect,
    input  logic       ev_load_use,
    input  logic       ev_id_redirect,
    input  logic       ev_struct,
    output logic [1:0] pc_sel,
    output logic       pc_hold,
    output logic       ifid_hold,
    output logic       ifid_bubble,
    output logic       idex_bubble
);
    // Resolve the highest-priority event into control outputs
    always_comb begin
        pc_sel      = PC_SEQ;
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        ifid_bubble = 1'b0;
        idex_bubble = 1'b0;
        if (!rst_n) begin
            pc_sel = PC_SEQ;
        end else if (ev_ex_redirect) begin
            pc_sel      = PC_EXE;
            ifid_bubble = 1'b1;
            idex_bubble = 1'b1;
        end else if (ev_load_use) begin
            pc_hold     = 1'b1;
            ifid_hold   = 1'b1;
            idex_bubble = 1'b1;
        end else if (ev_id_redirect) begin
            pc_sel      = PC_DEC;
            ifid_bubble = 1'b1;
        end else if (ev_struct) begin
            pc_hold     = 1'b1;
            ifid_bubble = 1'b1;
        end
    end

    // R11
    ifid_ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ifid_hold, ifid_bubble}));
    // R11
    hold_implies_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_hold |-> pc_hold);
    // R6
    ex_redirect_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ex_redirect |-> (!pc_hold && !ifid_hold && pc_sel == PC_EXE));
    // R4
    load_use_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_load_use && !ev_ex_redirect) |-> (idex_bubble && pc_hold));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard controller for an in-order five-stage pipeline.
// Bypass selects for the execute operands, load-use stalls, predict-not-taken
// redirects with wrong-path flush, and fetch stalls on a shared memory port.
// Assumes: all stage summaries are valid in the same cycle; no internal state.
module pipe_hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          id_valid,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use1,
    input  logic          id_use2,
    input  logic          id_uncond,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic          ex_cond,
    input  logic          ex_taken,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic          mem_acc,
    input  logic          wb_valid,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic [1:0]    pc_sel,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          ifid_bubble,
    output logic          idex_bubble
);
    localparam int NSRC = 2;

    logic [AW-1:0] src_vec [NSRC];
    logic [1:0]    sel_vec [NSRC];
    logic ev_ex_redirect, ev_load_use, ev_id_redirect, ev_struct;

    // Gather the execute operands for the per-operand bypass units
    always_comb begin
        src_vec[0] = ex_rs1;
        src_vec[1] = ex_rs2;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_fwd
        hzd_fwd_mux #(.AW(AW)) u_fwd (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (src_vec[g]),
            .mem_valid (mem_valid),
            .mem_wen   (mem_wen),
            .mem_rd    (mem_rd),
            .wb_valid  (wb_valid),
            .wb_wen    (wb_wen),
            .wb_rd     (wb_rd),
            .sel       (sel_vec[g])
        );
    end

    assign fwd_a = sel_vec[0];
    assign fwd_b = sel_vec[1];

    hzd_detect #(.AW(AW)) u_detect (
        .id_valid       (id_valid),
        .id_rs1         (id_rs1),
        .id_rs2         (id_rs2),
        .id_use1        (id_use1),
        .id_use2        (id_use2),
        .id_uncond      (id_uncond),
        .ex_valid       (ex_valid),
        .ex_rd          (ex_rd),
        .ex_wen         (ex_wen),
        .ex_load        (ex_load),
        .ex_cond        (ex_cond),
        .ex_taken       (ex_taken),
        .mem_valid      (mem_valid),
        .mem_acc        (mem_acc),
        .ev_ex_redirect (ev_ex_redirect),
        .ev_load_use    (ev_load_use),
        .ev_id_redirect (ev_id_redirect),
        .ev_struct      (ev_struct)
    );

    hzd_arbiter u_arb (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_ex_redirect (ev_ex_redirect),
        .ev_load_use    (ev_load_use),
        .ev_id_redirect (ev_id_redirect),
        .ev_struct      (ev_struct),
        .pc_sel         (pc_sel),
        .pc_hold        (pc_hold),
        .ifid_hold      (ifid_hold),
        .ifid_bubble    (ifid_bubble),
        .idex_bubble    (idex_bubble)
    );

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert ({fwd_a, fwd_b, pc_sel, pc_hold, ifid_hold,
                                      ifid_bubble, idex_bubble} == '0);
        end
    end
    // R3
    no_fwd_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && !wb_valid) |-> (fwd_a == FWD_RF && fwd_b == FWD_RF));
    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_valid && !ex_valid && !mem_valid) |-> (pc_sel == PC_SEQ && !pc_hold && !ifid_bubble));
endmodule

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic id_valid, id_use1, id_use2, id_uncond;
    logic [AW-1:0] id_rs1, id_rs2;
    logic ex_valid, ex_wen, ex_load, ex_cond, ex_taken;
    logic [AW-1:0] ex_rs1, ex_rs2, ex_rd;
    logic mem_valid, mem_wen, mem_acc;
    logic [AW-1:0] mem_rd;
    logic wb_valid, wb_wen;
    logic [AW-1:0] wb_rd;
    logic [1:0] fwd_a, fwd_b, pc_sel;
    logic pc_hold, ifid_hold, ifid_bubble, idex_bubble;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pipe_hazard_ctrl #(.AW(AW)) i_pipe_hazard_ctrl (.*);

    // Expected bypass select for one operand (R2/R3)
    function automatic logic [1:0] exp_fwd(input logic [AW-1:0] s);
        if (s == 0) return 2'b00;
        if (mem_valid && mem_wen && mem_rd == s) return 2'b10;
        if (wb_valid && wb_wen && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    // Expected packed outputs {fwd_a, fwd_b, pc_sel, pc_hold, ifid_hold, ifid_bubble, idex_bubble}
    function automatic logic [9:0] exp_out();
        logic lu;
        if (!rst_n) return 10'd0;
        lu = ex_valid && ex_load && ex_wen && ex_rd != 0 && id_valid &&
             ((id_use1 && id_rs1 == ex_rd) || (id_use2 && id_rs2 == ex_rd));
        if (ex_valid && ex_cond && ex_taken)
            return {exp_fwd(ex_rs1), exp_fwd(ex_rs2), 2'b10, 4'b0011};
        if (lu)
            return {exp_fwd(ex_rs1), exp_fwd(ex_rs2), 2'b00, 4'b1101};
        if (id_valid && id_uncond)
            return {exp_fwd(ex_rs1), exp_fwd(ex_rs2), 2'b01, 4'b0010};
        if (mem_valid && mem_acc)
            return {exp_fwd(ex_rs1), exp_fwd(ex_rs2), 2'b00, 4'b1010};
        return {exp_fwd(ex_rs1), exp_fwd(ex_rs2), 2'b00, 4'b0000};
    endfunction

    task automatic clear_in();
        {id_valid, id_use1, id_use2, id_uncond} = '0;
        id_rs1 = '0; id_rs2 = '0;
        {ex_valid, ex_wen, ex_load, ex_cond, ex_taken} = '0;
        ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
        {mem_valid, mem_wen, mem_acc} = '0; mem_rd = '0;
        {wb_valid, wb_wen} = '0; wb_rd = '0;
    endtask

    // Compare the outputs with the bench model, tagged by requirement
    task automatic check(input string req);
        logic [9:0] act;
        logic [9:0] exp;
        #1;
        act = {fwd_a, fwd_b, pc_sel, pc_hold, ifid_hold, ifid_bubble, idex_bubble};
        exp = exp_out();
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_val(input string req, input logic [9:0] want);
        logic [9:0] act;
        #1;
        act = {fwd_a, fwd_b, pc_sel, pc_hold, ifid_hold, ifid_bubble, idex_bubble};
        checks++;
        if (act !== want) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, want);
        end
    endtask

    task automatic randomize_in();
        id_valid = ($urandom_range(0, 3) != 0); id_use1 = $urandom_range(0, 1);
        id_use2 = $urandom_range(0, 1); id_uncond = ($urandom_range(0, 7) == 0);
        id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
        ex_valid = ($urandom_range(0, 3) != 0); ex_wen = $urandom_range(0, 1);
        ex_load = $urandom_range(0, 1); ex_cond = ($urandom_range(0, 5) == 0);
        ex_taken = $urandom_range(0, 1);
        ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
        ex_rd = AW'($urandom_range(0, 3));
        mem_valid = ($urandom_range(0, 3) != 0); mem_wen = $urandom_range(0, 1);
        mem_acc = ($urandom_range(0, 3) == 0); mem_rd = AW'($urandom_range(0, 3));
        wb_valid = ($urandom_range(0, 3) != 0); wb_wen = $urandom_range(0, 1);
        wb_rd = AW'($urandom_range(0, 3));
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        clear_in();
        // R1: reset forces all controls quiet even with hazards present
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            randomize_in();
            ex_valid = 1; ex_cond = 1; ex_taken = 1; mem_valid = 1; mem_wen = 1;
            mem_rd = 3; ex_rs1 = 3;
            check_val("R1", 10'd0);
        end
        @(negedge clk); rst_n = 1'b1; clear_in();
        check_val("R10", 10'd0);

        // R2: memory stage beats write-back on the same register
        @(negedge clk); clear_in();
        ex_valid = 1; ex_rs1 = 7; ex_rs2 = 9;
        mem_valid = 1; mem_wen = 1; mem_rd = 7;
        wb_valid = 1; wb_wen = 1; wb_rd = 7;
        check_val("R2", {2'b10, 2'b00, 2'b00, 4'b0000});
        @(negedge clk); mem_rd = 9; wb_rd = 7;
        check_val("R2", {2'b01, 2'b10, 2'b00, 4'b0000});

        // R3: register 0 and non-writing stages never bypass
        @(negedge clk); clear_in();
        ex_valid = 1; ex_rs1 = 0; ex_rs2 = 4;
        mem_valid = 1; mem_wen = 1; mem_rd = 0;
        wb_valid = 1; wb_wen = 0; wb_rd = 4;
        check_val("R3", 10'd0);

        // R4: load-use stall
        @(negedge clk); clear_in();
        ex_valid = 1; ex_load = 1; ex_wen = 1; ex_rd = 5;
        id_valid = 1; id_use2 = 1; id_rs2 = 5;
        check_val("R4", {4'b0000, 2'b00, 4'b1101});

        // R5: matching register but not read -> no stall
        @(negedge clk); id_use2 = 0; id_use1 = 1; id_rs1 = 6;
        check_val("R5", 10'd0);

        // R6: taken conditional branch beats load-use and structural (R9)
        @(negedge clk); clear_in();
        ex_valid = 1; ex_load = 1; ex_wen = 1; ex_rd = 5; ex_cond = 1; ex_taken = 1;
        id_valid = 1; id_use1 = 1; id_rs1 = 5; mem_valid = 1; mem_acc = 1;
        check_val("R6", {4'b0000, 2'b10, 4'b0011});

        // R10: not-taken conditional branch is no event
        @(negedge clk); clear_in();
        ex_valid = 1; ex_cond = 1; ex_taken = 0;
        check_val("R10", 10'd0);

        // R7: unconditional branch in decode
        @(negedge clk); clear_in();
        id_valid = 1; id_uncond = 1;
        check_val("R7", {4'b0000, 2'b01, 4'b0010});

        // R9: load-use beats a jump in decode
        @(negedge clk); ex_valid = 1; ex_load = 1; ex_wen = 1; ex_rd = 2;
        id_use1 = 1; id_rs1 = 2;
        check_val("R9", {4'b0000, 2'b00, 4'b1101});

        // R9: jump beats structural conflict
        @(negedge clk); clear_in();
        id_valid = 1; id_uncond = 1; mem_valid = 1; mem_acc = 1;
        check_val("R9", {4'b0000, 2'b01, 4'b0010});

        // R8: structural conflict alone
        @(negedge clk); id_uncond = 0;
        check_val("R8", {4'b0000, 2'b00, 4'b1010});

        // R11: load-use with structural keeps hold, no bubble on decode
        @(negedge clk); ex_valid = 1; ex_load = 1; ex_wen = 1; ex_rd = 1;
        id_use1 = 1; id_rs1 = 1;
        check_val("R11", {4'b0000, 2'b00, 4'b1101});

        // Random mix against the bench model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            randomize_in();
            check("R2/R4/R6/R7/R8/R9");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule